// File: doc/BRIEF.md
# Self-Clearing Reset Control Register with Card-Clock Handshake

This block is the reset control register of a card-interface controller. Software writes it over a simple register port in the bus clock domain. Three of its bits request resets. Each bit sets when software writes a 1 to it, and each clears itself without further software action. The three resets go to the controller core, to the data FIFO pointers and to the DMA interface control logic. Bit 3 is reserved.

The FIFO and DMA resets live entirely in the bus clock domain. Each one is asserted for a fixed two bus cycles. The controller-core reset must also reach logic clocked by the card clock. Its request crosses through a two-flop synchronizer into the card domain. There a small state machine holds the card-side reset for a fixed number of card cycles and then raises an acknowledge. The acknowledge returns through a second two-flop synchronizer. The bit stays set until the request/acknowledge handshake has closed, so a 0 on readback means that both domains have been reset and released.

Readback always shows the live state of every bit, so software can poll until the register reads zero. The core reset is meant for the bus-to-card bridge, the card-side state machines and the transient command and read-control flags. It leaves the configuration registers, the FIFO, the DMA logic and pending interrupt flags alone. Those consumers only need to decide which of the three outputs they sample.

Top module: `card_rst_ctrl`

State machines:
- Self-clearing bit (`card_rst_pulse`)
  - P_IDLE goes to P_HOLD when a 1 is written to the bit.
  - P_HOLD returns to P_IDLE once HOLD cycles have elapsed.
- Bus side of the core reset (`card_rst_bus_fsm`)
  - B_IDLE goes to B_REQ when a 1 is written to bit 0.
  - B_REQ goes to B_DRAIN when the synchronized acknowledge is high and at least MIN_CYC bus cycles have elapsed.
  - B_DRAIN goes to B_IDLE when the synchronized acknowledge has dropped.
- Card side of the core reset (`card_rst_card_fsm`)
  - C_IDLE goes to C_HOLD when the synchronized request rises.
  - C_HOLD goes to C_ACK after HOLD card cycles.
  - C_ACK goes to C_IDLE when the synchronized request drops.

## Requirements
- R1: After power-on reset all register bits read 0. Bit 0 is the core reset, bit 1 the FIFO reset and bit 2 the DMA reset. Bit 3 reads 0 regardless of what is written to it.
- R2: Writing 0 to any bit has no effect, either when the bit is clear or when it is set.
- R3: Writing 1 to bit 1 sets it from the next bus clock edge. The bit reads 1 for exactly two bus cycles. `fifo_rst` equals bit 1 at all times.
- R4: Writing 1 to bit 2 sets it from the next bus clock edge. The bit reads 1 for exactly two bus cycles. `dma_rst` equals bit 2 at all times.
- R5: Bit 0 reads 1 for at least two bus cycles, and `core_rst_card` is asserted for at least two card cycles before bit 0 clears. Bit 0 clears within 40 bus cycles.
- R6: Writing 1 to a bit that is already set is ignored. The running sequence neither restarts nor extends, and a core sequence produces exactly one card-side reset pulse.
- R7: The three resets are independent. A core reset sequence leaves bits 1 and 2 unchanged, and FIFO or DMA writes do not touch bit 0.
- R8: `core_rst_bus` equals bit 0 at all times. `core_rst_card` is never asserted while bit 0 reads 0, so the card-side reset has been released by the time bit 0 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low power-on reset, bus domain |
| card_clk | input | 1 | Card clock |
| card_rst_n | input | 1 | Active-low power-on reset, card domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data (bit 0 core, bit 1 FIFO, bit 2 DMA, bit 3 reserved) |
| rd_data | output | 4 | Live readback of the register |
| core_rst_bus | output | 1 | Core reset, bus domain, active high |
| core_rst_card | output | 1 | Core reset, card domain, active high |
| fifo_rst | output | 1 | FIFO pointer reset, active high |
| dma_rst | output | 1 | DMA interface reset, active high |

## Verification
Every cycle, the assertions check the following:
- The FIFO and DMA pulses last exactly two bus cycles.
- Neither pulse appears without a write of 1.
- The core reset lasts at least two cycles in each domain.
- The card-side reset is already low whenever the core bit falls.

Only the bench scenarios can show the rest: that a repeated write yields a single card-side pulse, that the core sequence finishes within its bound, and that simultaneous writes to all three bits keep the bits independent. The bench does this against a cycle model of the two fixed-length bits and pulse counters in the card domain.

// File: rtl/card_rst_pkg.sv
package card_rst_pkg;
    localparam int REG_W    = 4;
    localparam int CORE_BIT = 0;
    localparam int FIFO_BIT = 1;
    localparam int DMA_BIT  = 2;

    typedef enum logic {P_IDLE, P_HOLD} pulse_st_t;
    typedef enum logic [1:0] {B_IDLE, B_REQ, B_DRAIN} bus_st_t;
    typedef enum logic [1:0] {C_IDLE, C_HOLD, C_ACK} card_st_t;
endpackage

// File: rtl/card_rst_sync.sv
module card_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/card_rst_pulse.sv
module card_rst_pulse
    import card_rst_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);

    pulse_st_t      state, state_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= P_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            P_IDLE: begin
                if (set) begin
                    state_nxt = P_HOLD;
                    cnt_nxt   = '0;
                end
            end
            P_HOLD: begin
                if (cnt == CW'(HOLD - 1)) state_nxt = P_IDLE;
                else                      cnt_nxt   = cnt + 1'b1;
            end
            default: state_nxt = P_IDLE;
        endcase
    end

    assign active = (state == P_HOLD);
endmodule

// File: rtl/card_rst_bus_fsm.sv
module card_rst_bus_fsm
    import card_rst_pkg::*;
#(
    parameter int MIN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_s,
    output logic req,
    output logic busy
);
    localparam int MW = $clog2(MIN_CYC + 1);

    bus_st_t        state, state_nxt;
    logic [MW-1:0]  cnt, cnt_nxt;
    logic           min_met;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= B_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign min_met = (cnt == MW'(MIN_CYC - 1));

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            B_IDLE: begin
                if (start) begin
                    state_nxt = B_REQ;
                    cnt_nxt   = '0;
                end
            end
            B_REQ: begin
                if (!min_met)              cnt_nxt   = cnt + 1'b1;
                else if (ack_s)            state_nxt = B_DRAIN;
            end
            B_DRAIN: begin
                if (!ack_s) state_nxt = B_IDLE;
            end
            default: state_nxt = B_IDLE;
        endcase
    end

    assign req  = (state == B_REQ);
    assign busy = (state != B_IDLE);
endmodule

// File: rtl/card_rst_card_fsm.sv
module card_rst_card_fsm
    import card_rst_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic ack,
    output logic core_rst
);
    localparam int CW = $clog2(HOLD + 1);

    card_st_t       state, state_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= C_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            C_IDLE: begin
                if (req_s) begin
                    state_nxt = C_HOLD;
                    cnt_nxt   = '0;
                end
            end
            C_HOLD: begin
                if (cnt == CW'(HOLD - 1)) state_nxt = C_ACK;
                else                      cnt_nxt   = cnt + 1'b1;
            end
            C_ACK: begin
                if (!req_s) state_nxt = C_IDLE;
            end
            default: state_nxt = C_IDLE;
        endcase
    end

    assign ack      = (state == C_ACK);
    assign core_rst = (state != C_IDLE);
endmodule

// File: rtl/card_rst_ctrl.sv
module card_rst_ctrl
    import card_rst_pkg::*;
#(
    parameter int SC_HOLD    = 2,
    parameter int CORE_BUS   = 2,
    parameter int CORE_CARD  = 2,
    parameter int SYNC_STAGE = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             card_clk,
    input  logic             card_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             core_rst_bus,
    output logic             core_rst_card,
    output logic             fifo_rst,
    output logic             dma_rst
);
    localparam int NSC = 2;

    logic [NSC-1:0] sc_set;
    logic [NSC-1:0] sc_act;
    logic           core_req, core_busy, req_card, ack_card, ack_bus;
    logic           unused_rsvd;

    assign unused_rsvd = wr_data[REG_W-1];

    // FIFO and DMA bits: bits FIFO_BIT and DMA_BIT, consecutive
    for (genvar i = 0; i < NSC; i++) begin : g_sc
        assign sc_set[i] = wr_en & wr_data[FIFO_BIT + i];
        card_rst_pulse #(.HOLD(SC_HOLD)) u_pulse (
            .clk    (bus_clk),
            .rst_n  (bus_rst_n),
            .set    (sc_set[i]),
            .active (sc_act[i])
        );
    end

    card_rst_bus_fsm #(.MIN_CYC(CORE_BUS)) u_bus_fsm (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .start (wr_en & wr_data[CORE_BIT]),
        .ack_s (ack_bus),
        .req   (core_req),
        .busy  (core_busy)
    );

    card_rst_sync #(.STAGES(SYNC_STAGE)) u_req_sync (
        .clk   (card_clk),
        .rst_n (card_rst_n),
        .d     (core_req),
        .q     (req_card)
    );

    card_rst_card_fsm #(.HOLD(CORE_CARD)) u_card_fsm (
        .clk      (card_clk),
        .rst_n    (card_rst_n),
        .req_s    (req_card),
        .ack      (ack_card),
        .core_rst (core_rst_card)
    );

    card_rst_sync #(.STAGES(SYNC_STAGE)) u_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (ack_card),
        .q     (ack_bus)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[CORE_BIT] = core_busy;
        rd_data[FIFO_BIT] = sc_act[0];
        rd_data[DMA_BIT]  = sc_act[1];
    end

    assign core_rst_bus = core_busy;
    assign fifo_rst     = sc_act[0];
    assign dma_rst      = sc_act[1];
endmodule

// File: rtl/card_rst_ctrl_chk.sv
module card_rst_ctrl_chk (
    input logic       bus_clk,
    input logic       bus_rst_n,
    input logic       card_clk,
    input logic       card_rst_n,
    input logic       wr_en,
    input logic [3:0] wr_data,
    input logic [3:0] rd_data,
    input logic       core_rst_bus,
    input logic       core_rst_card,
    input logic       fifo_rst,
    input logic       dma_rst
);
    // R3
    fifo_min_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(fifo_rst) |=> fifo_rst);
    // R3
    fifo_max_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (fifo_rst && $past(fifo_rst)) |=> !fifo_rst);
    // R4
    dma_min_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(dma_rst) |=> dma_rst);
    // R4
    dma_max_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (dma_rst && $past(dma_rst)) |=> !dma_rst);
    // R2
    fifo_no_spurious_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!fifo_rst && !(wr_en && wr_data[1])) |=> !fifo_rst);
    // R2
    dma_no_spurious_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (!dma_rst && !(wr_en && wr_data[2])) |=> !dma_rst);
    // R5
    core_bus_min_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(core_rst_bus) |=> core_rst_bus);
    // R5
    core_card_min_chk: assert property (@(posedge card_clk) disable iff (!card_rst_n)
        $rose(core_rst_card) |=> core_rst_card);
    // R8
    core_card_released_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $fell(rd_data[0]) |-> !core_rst_card);
endmodule

bind card_rst_ctrl card_rst_ctrl_chk u_chk (.*);

// File: tb/card_rst_ctrl_tb.sv
`timescale 1ns/1ps
module card_rst_ctrl_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int CARD_PERIOD = 13;
    localparam int WATCHDOG    = 50000;

    logic       bus_clk = 0, card_clk = 0;
    logic       bus_rst_n = 0, card_rst_n = 0;
    logic       wr_en = 0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic       core_rst_bus, core_rst_card, fifo_rst, dma_rst;

    int checks = 0, failures = 0, cyc = 0;
    int core_hi = 0, card_hi = 0, card_rises = 0;
    bit card_prev = 0;
    bit m_fifo = 0, m_dma = 0;
    int f_cnt = 0, d_cnt = 0;
    bit done = 0;

    card_rst_ctrl u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .card_clk(card_clk), .card_rst_n(card_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .core_rst_bus(core_rst_bus), .core_rst_card(core_rst_card),
        .fifo_rst(fifo_rst), .dma_rst(dma_rst)
    );

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    initial begin
        #3;
        forever #(CARD_PERIOD/2.0) card_clk = ~card_clk;
    end

    always @(posedge card_clk) begin
        if (core_rst_card && !card_prev) card_rises++;
        if (core_rst_card) card_hi++;
        card_prev = core_rst_card;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one bus cycle: inputs applied at negedge, model advanced at posedge, compared at next negedge
    task automatic step(input logic we, input logic [3:0] d);
        wr_en = we;
        wr_data = d;
        @(posedge bus_clk);
        #1;
        if (m_fifo) begin
            f_cnt++;
            if (f_cnt == 2) m_fifo = 0;
        end else if (we && d[1]) begin
            m_fifo = 1; f_cnt = 0;
        end
        if (m_dma) begin
            d_cnt++;
            if (d_cnt == 2) m_dma = 0;
        end else if (we && d[2]) begin
            m_dma = 1; d_cnt = 0;
        end
        wr_en = 0;
        wr_data = '0;
        @(negedge bus_clk);
        check(rd_data[1] == m_fifo, "R3 fifo bit vs model", rd_data[1], m_fifo);
        check(fifo_rst == rd_data[1], "R3 fifo_rst follows bit", fifo_rst, rd_data[1]);
        check(rd_data[2] == m_dma, "R4 dma bit vs model", rd_data[2], m_dma);
        check(dma_rst == rd_data[2], "R4 dma_rst follows bit", dma_rst, rd_data[2]);
        check(rd_data[3] == 1'b0, "R1 reserved bit reads 0", rd_data[3], 0);
        check(core_rst_bus == rd_data[0], "R8 core_rst_bus follows bit", core_rst_bus, rd_data[0]);
        if (!rd_data[0])
            check(core_rst_card == 1'b0, "R8 card reset low while bit clear", core_rst_card, 0);
        if (rd_data[0]) core_hi++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 4'b0000);
    endtask

    // wait for the core bit to clear, then check R5 durations and pulse count
    task automatic finish_core(input string tag);
        int waited = 0;
        while (rd_data[0] && waited < 60) begin
            step(0, 4'b0000);
            waited++;
        end
        check(rd_data[0] == 1'b0, {"R5 core bit clears ", tag}, rd_data[0], 0);
        check(waited <= 40, {"R5 clear bound ", tag}, waited, 40);
        check(core_hi >= 2, {"R5 bus hold ", tag}, core_hi, 2);
        check(card_hi >= 2, {"R5 card hold ", tag}, card_hi, 2);
        check(card_rises == 1, {"R6 single card pulse ", tag}, card_rises, 1);
    endtask

    task automatic clear_counts();
        core_hi = 0;
        card_hi = 0;
        card_rises = 0;
    endtask

    initial begin
        repeat (3) @(negedge bus_clk);
        // R1 reset state
        check(rd_data == 4'b0000, "R1 reset readback", rd_data, 0);
        check({core_rst_bus, core_rst_card, fifo_rst, dma_rst} == 4'b0, "R1 reset outputs", 
              {core_rst_bus, core_rst_card, fifo_rst, dma_rst}, 0);
        bus_rst_n = 1;
        card_rst_n = 1;
        idle(3);

        // R2 writing zero while idle
        step(1, 4'b0000);
        check(rd_data == 4'b0000, "R2 zero write idle", rd_data, 0);

        // R1 reserved bit write
        step(1, 4'b1000);
        check(rd_data == 4'b0000, "R1 reserved write ignored", rd_data, 0);

        // R3 fifo pulse
        step(1, 4'b0010);
        check(rd_data == 4'b0010, "R3 fifo set", rd_data, 2);
        step(0, 4'b0000);
        check(rd_data == 4'b0010, "R3 fifo second cycle", rd_data, 2);
        step(0, 4'b0000);
        check(rd_data == 4'b0000, "R3 fifo cleared", rd_data, 0);

        // R4 dma pulse
        step(1, 4'b0100);
        step(0, 4'b0000);
        check(rd_data == 4'b0100, "R4 dma second cycle", rd_data, 4);
        step(0, 4'b0000);
        check(rd_data == 4'b0000, "R4 dma cleared", rd_data, 0);

        // R6 rewrite while set: no restart
        step(1, 4'b0010);
        step(1, 4'b0010);
        step(0, 4'b0000);
        check(rd_data[1] == 1'b0, "R6 fifo no restart", rd_data[1], 0);

        // R2 writing zero while set
        step(1, 4'b0100);
        step(1, 4'b0000);
        check(rd_data[2] == 1'b1, "R2 zero write keeps dma", rd_data[2], 1);
        idle(2);

        // R5 R7 core alone
        clear_counts();
        step(1, 4'b0001);
        check(rd_data == 4'b0001, "R7 core only set", rd_data, 1);
        idle(3);
        check(rd_data[2:1] == 2'b00, "R7 fifo/dma untouched", rd_data[2:1], 0);
        finish_core("single");
        idle(10);
        check(card_rises == 1 && !core_rst_card, "R8 card quiet after clear", card_rises, 1);

        // R6 core rewrite during sequence
        clear_counts();
        step(1, 4'b0001);
        idle(2);
        step(1, 4'b0001);
        step(1, 4'b0001);
        finish_core("rewrite");
        idle(10);
        check(card_rises == 1, "R6 no second core pulse", card_rises, 1);

        // R7 all three together, then fifo during core
        clear_counts();
        step(1, 4'b0111);
        check(rd_data == 4'b0111, "R7 all set", rd_data, 7);
        idle(2);
        check(rd_data[2:1] == 2'b00 && rd_data[0], "R7 fifo/dma clear, core held", rd_data, 1);
        step(1, 4'b0010);
        check(rd_data[0] == 1'b1, "R7 fifo write keeps core", rd_data[0], 1);
        finish_core("together");
        idle(5);

        done = 1;
        summary();
    end
endmodule